// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block carries one direction of traffic between two clock domains. Words are written on `wr_clk` and read on `rd_clk`. The two clocks may be unrelated or may be the same clock. The storage holds 64 words of 36 bits.

Each side sees only the flags that belong to it, and those flags are registered in its own clock. The write side gets full and almost-full. The read side gets empty and almost-empty. Before a pointer crosses to the other domain, it is converted to Gray code and passed through a two-stage synchronizer.

The two almost thresholds are offsets that can be set from software. They are captured from the write data bus while the block is held in reset. When nothing is loaded, a default is used.

Top module: `fifo_dual_clk`

## Requirements
- R1: Words leave on the read side in exactly the order they were accepted on the write side. The array holds up to 64 words of 36 bits, with no loss or duplication, for any ratio between the two clocks.
- R2: While `rst_n` is low and just after it rises, `rd_empty` and `rd_aempty` read 1, and `wr_full` and `wr_afull` read 0.
- R3: Both 7-bit pointers that cross domains are Gray coded. From one cycle of their own clock to the next, each changes in at most one bit.
- R4: A write attempted while `wr_full` is 1 is ignored. The write pointer does not move, and the offered word is never delivered on the read side.
- R5: A read attempted while `rd_empty` is 1 is ignored. The read pointer does not move, and `rd_data` keeps its previous value.
- R6: Once the write side has settled, `wr_full` is 1 exactly when 64 words are stored. It can only rise in the cycle after an accepted write.
- R7: Once the read side has settled, `rd_empty` is 1 exactly when no word is stored. It can only rise in the cycle after an accepted read.
- R8: Once settled, `wr_afull` is 1 exactly when the stored count is at least 64 minus the almost-full offset. `wr_full` implies `wr_afull`.
- R9: Once settled, `rd_aempty` is 1 exactly when the stored count is at most the almost-empty offset. `rd_empty` implies `rd_aempty`.
- R10: On every `wr_clk` rising edge while `rst_n` is low, the offsets are written.
  - If `ofs_ld` is 1, the almost-full offset takes `wr_data[5:0]` and the almost-empty offset takes `wr_data[11:6]`.
  - Otherwise both offsets become 8.
- R11: An accepted read presents its word on `rd_data` after the same `rd_clk` rising edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides; offsets are captured while it is low |
| ofs_ld | input | 1 | During reset, take offsets from `wr_data` instead of the default |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | 36 | Word to store; also carries offsets during reset |
| wr_full | output | 1 | All 64 locations occupied (write domain) |
| wr_afull | output | 1 | Count at or above the almost-full threshold (write domain) |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | 36 | Last word read |
| rd_empty | output | 1 | No word stored (read domain) |
| rd_aempty | output | 1 | Count at or below the almost-empty threshold (read domain) |

## Verification
The hardest state to reach is a completely full array, followed by writes that must be dropped, followed by a drain past the pointer wrap. A dropped word only shows up later, as a wrong word in the output stream.

The stimulus fills the array to exactly 64 words, offers three marked words while full, and drains all 64. It then sends one more word, which proves that no marked word got through and that both pointers wrapped cleanly.

Each threshold edge is approached one word at a time. The stored count is held still until both synchronizers have caught up, so every flag is sampled at a settled count on both sides of its boundary. This is done once with the default offsets and once with loaded offsets.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;

    parameter int FIFO_SYNC_STAGES = 2;
    parameter int FIFO_DEF_OFS     = 8;

    // Prefix XOR across the word turns a Gray code back into binary.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        b = b ^ (b >> 1);
        b = b ^ (b >> 2);
        b = b ^ (b >> 4);
        b = b ^ (b >> 8);
        b = b ^ (b >> 16);
        return b;
    endfunction

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/fifo_dc_sync.sv
module fifo_dc_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/fifo_dc_wr_ctl.sv
module fifo_dc_wr_ctl #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_gray_s,
    input  logic [ADDR_W-1:0] af_ofs,
    output logic [ADDR_W:0]   wr_gray,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_push,
    output logic              full,
    output logic              afull
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
    } wst_t;

    wst_t          st_d, st_q;
    logic          push;
    logic [PW-1:0] rd_bin, used, thr;

    always_comb begin
        st_d   = st_q;
        push   = wr_en && !st_q.full;
        rd_bin = PW'(fifo_dc_pkg::gray_to_bin(32'(rd_gray_s)));
        if (push) st_d.bin = st_q.bin + 1'b1;
        st_d.gray  = PW'(fifo_dc_pkg::bin_to_gray(32'(st_d.bin)));
        used       = st_d.bin - rd_bin;
        thr        = DEPTH_V - {1'b0, af_ofs};
        st_d.full  = (used == DEPTH_V);
        st_d.afull = (used >= thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_gray = st_q.gray;
    assign wr_addr = st_q.bin[ADDR_W-1:0];
    assign wr_push = push;
    assign full    = st_q.full;
    assign afull   = st_q.afull;
endmodule

// File: rtl/fifo_dc_rd_ctl.sv
module fifo_dc_rd_ctl #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W:0]   rd_gray,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_pop,
    output logic              empty,
    output logic              aempty
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          aempty;
    } rst_t;

    rst_t          st_d, st_q;
    logic          pop;
    logic [PW-1:0] wr_bin, used;

    always_comb begin
        st_d   = st_q;
        pop    = rd_en && !st_q.empty;
        wr_bin = PW'(fifo_dc_pkg::gray_to_bin(32'(wr_gray_s)));
        if (pop) st_d.bin = st_q.bin + 1'b1;
        st_d.gray   = PW'(fifo_dc_pkg::bin_to_gray(32'(st_d.bin)));
        used        = wr_bin - st_d.bin;
        st_d.empty  = (st_d.gray == wr_gray_s);
        st_d.aempty = (used <= {1'b0, ae_ofs});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1};
        else        st_q <= st_d;
    end

    assign rd_gray = st_q.gray;
    assign rd_addr = st_q.bin[ADDR_W-1:0];
    assign rd_pop  = pop;
    assign empty   = st_q.empty;
    assign aempty  = st_q.aempty;
endmodule

// File: rtl/fifo_dc_mem.sv
module fifo_dc_mem #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_push,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_pop,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdat_d, rdat_q;

    always_ff @(posedge wr_clk) begin
        if (wr_push) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        rdat_d = rdat_q;
        if (rd_pop) rdat_d = mem_q[rd_addr];
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rdat_q <= '0;
        else        rdat_q <= rdat_d;
    end

    assign rd_data = rdat_q;
endmodule

// File: rtl/fifo_dual_clk.sv
module fifo_dual_clk #(
    parameter int DATA_W      = 36,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = fifo_dc_pkg::FIFO_SYNC_STAGES,
    parameter int DEF_OFS     = fifo_dc_pkg::FIFO_DEF_OFS
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              ofs_ld,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_afull,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_aempty
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] af;
        logic [ADDR_W-1:0] ae;
    } ofs_t;

    ofs_t              ofs_d, ofs_q;
    logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_push, rd_pop;

    // Offsets are written on each write-clock edge while reset is held.
    always_comb begin
        ofs_d = ofs_q;
        if (!rst_n) begin
            if (ofs_ld) begin
                ofs_d.af = wr_data[ADDR_W-1:0];
                ofs_d.ae = wr_data[2*ADDR_W-1:ADDR_W];
            end else begin
                ofs_d.af = ADDR_W'(DEF_OFS);
                ofs_d.ae = ADDR_W'(DEF_OFS);
            end
        end
    end

    always_ff @(posedge wr_clk) ofs_q <= ofs_d;

    fifo_dc_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
        .af_ofs(ofs_q.af), .wr_gray(wr_gray), .wr_addr(wr_addr),
        .wr_push(wr_push), .full(wr_full), .afull(wr_afull)
    );

    fifo_dc_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wr_gray_s(wr_gray_s),
        .ae_ofs(ofs_q.ae), .rd_gray(rd_gray), .rd_addr(rd_addr),
        .rd_pop(rd_pop), .empty(rd_empty), .aempty(rd_aempty)
    );

    fifo_dc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    fifo_dc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    fifo_dc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .wr_push(wr_push), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_pop(rd_pop), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/fifo_dc_chk.sv
module fifo_dc_chk #(
    parameter int PW = 7
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_full,
    input logic          wr_afull,
    input logic          rd_empty,
    input logic          rd_aempty,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] rd_gray
);
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_full && wr_en) |=> $stable(wr_gray)); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_empty && rd_en) |=> $stable(rd_gray)); // R5

    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R3

    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1); // R3

    AST_FULL_AFTER_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(wr_full) |-> $past(wr_en)); // R6

    AST_EMPTY_AFTER_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(rd_empty) |-> $past(rd_en)); // R7

    AST_FULL_IN_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_full |-> wr_afull); // R8

    AST_EMPTY_IN_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_empty |-> rd_aempty); // R9
endmodule

bind fifo_dual_clk fifo_dc_chk #(.PW(ADDR_W + 1)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_full(wr_full), .wr_afull(wr_afull), .rd_empty(rd_empty), .rd_aempty(rd_aempty),
    .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/sim_fifo_dual_clk.sv
module sim_fifo_dual_clk;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        rst_n = 1'b0, ofs_ld = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        wr_full, wr_afull, rd_empty, rd_aempty;

    logic [35:0] exp_q [$];
    int          n_tests = 0, n_fail = 0;
    int          seq = 0, rx_cnt = 0;
    logic        rd_acc_nx = 1'b0, mon_acc;
    logic [35:0] last_rd = '0, mon_exp;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    fifo_dual_clk u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_ld(ofs_ld),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full), .wr_afull(wr_afull),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .rd_aempty(rd_aempty)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] pattern(input int s);
        return 36'(s * 32'h9E3779B1) ^ 36'(s);
    endfunction

    // Monitor: pops the scoreboard for each read the driver saw accepted (R1, R11)
    always @(posedge rd_clk) begin
        mon_acc = rd_acc_nx;
        #3;
        if (mon_acc) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 read with empty scoreboard", rd_data, '0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(rd_data == mon_exp, "R1/R11 word order", rd_data, mon_exp);
            end
            last_rd = rd_data;
            rx_cnt++;
        end
    end

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    // Driver: offers one word; the word is expected only when not full (R4)
    task automatic put(input logic [35:0] v);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = v;
        if (!wr_full) exp_q.push_back(v);
    endtask

    task automatic put_n(input int n);
        for (int i = 0; i < n; i++) begin
            put(pattern(seq));
            seq++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        settle();
    endtask

    task automatic get_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en     = 1'b1;
            rd_acc_nx = !rd_empty;
        end
        @(negedge rd_clk);
        rd_en     = 1'b0;
        rd_acc_nx = 1'b0;
        settle();
    endtask

    task automatic do_reset(input bit ld, input logic [5:0] af, input logic [5:0] ae);
        @(negedge wr_clk);
        rst_n     = 1'b0;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        rd_acc_nx = 1'b0;
        ofs_ld    = ld;
        wr_data   = {24'd0, ae, af};
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
        chk(rd_empty && rd_aempty && !wr_full && !wr_afull, "R2 flags during reset",
            {32'd0, rd_empty, rd_aempty, wr_full, wr_afull}, 36'b1100);
        rst_n  = 1'b1;
        ofs_ld = 1'b0;
        exp_q.delete();
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Default offsets (8 / 8)
        do_reset(1'b0, 6'd0, 6'd0);
        chk(rd_empty && rd_aempty && !wr_full && !wr_afull, "R2 flags after reset",
            {32'd0, rd_empty, rd_aempty, wr_full, wr_afull}, 36'b1100);

        put_n(8);
        chk(rd_aempty == 1'b1, "R9/R10 aempty at count 8 with default offset", 36'(rd_aempty), 36'd1);
        chk(rd_empty == 1'b0, "R7 not empty at count 8", 36'(rd_empty), 36'd0);
        put_n(1);
        chk(rd_aempty == 1'b0, "R9/R10 aempty clear at count 9", 36'(rd_aempty), 36'd0);
        put_n(46);
        chk(wr_afull == 1'b0, "R8/R10 afull clear at count 55", 36'(wr_afull), 36'd0);
        put_n(1);
        chk(wr_afull == 1'b1, "R8/R10 afull at count 56", 36'(wr_afull), 36'd1);
        chk(wr_full == 1'b0, "R6 not full at count 56", 36'(wr_full), 36'd0);
        put_n(8);
        chk(wr_full == 1'b1, "R6 full at count 64", 36'(wr_full), 36'd1);

        // Writes while full carry a marker word that must never come out (R4)
        for (int i = 0; i < 3; i++) put(36'hDEADBEEF0);
        @(negedge wr_clk);
        wr_en = 1'b0;
        settle();
        chk(exp_q.size() == 64, "R4 writes while full not accepted", 36'(exp_q.size()), 36'd64);

        get_n(64);
        chk(rx_cnt == 64, "R1 all 64 words delivered", 36'(rx_cnt), 36'd64);
        chk(rd_empty && rd_aempty, "R7 empty after drain", {34'd0, rd_empty, rd_aempty}, 36'b11);
        chk(!wr_full && !wr_afull, "R6 full clear after drain", {34'd0, wr_full, wr_afull}, 36'b00);

        // Reads while empty (R5)
        for (int i = 0; i < 3; i++) begin
            @(negedge rd_clk);
            rd_en     = 1'b1;
            rd_acc_nx = !rd_empty;
        end
        @(negedge rd_clk);
        rd_en     = 1'b0;
        rd_acc_nx = 1'b0;
        settle();
        chk(rd_data == last_rd, "R5 rd_data held on read while empty", rd_data, last_rd);
        chk(rd_empty == 1'b1, "R5 still empty", 36'(rd_empty), 36'd1);

        // One word across the wrap proves both pointers intact (R4, R5)
        put_n(1);
        get_n(1);
        chk(rx_cnt == 65 && exp_q.size() == 0, "R4/R5 post-wrap word", 36'(rx_cnt), 36'd65);

        // Loaded offsets: almost-full 3, almost-empty 2 (R10)
        do_reset(1'b1, 6'd3, 6'd2);
        put_n(2);
        chk(rd_aempty == 1'b1, "R9/R10 aempty at count 2 with offset 2", 36'(rd_aempty), 36'd1);
        put_n(1);
        chk(rd_aempty == 1'b0, "R9/R10 aempty clear at count 3", 36'(rd_aempty), 36'd0);
        put_n(57);
        chk(wr_afull == 1'b0, "R8/R10 afull clear at count 60 with offset 3", 36'(wr_afull), 36'd0);
        put_n(1);
        chk(wr_afull == 1'b1, "R8/R10 afull at count 61", 36'(wr_afull), 36'd1);
        rx_cnt = 0;
        get_n(61);
        chk(rx_cnt == 61 && rd_empty, "R1/R7 drain after offset test", 36'(rx_cnt), 36'd61);

        // Concurrent streaming with irregular enables (R1)
        rx_cnt = 0;
        fork
            begin
                for (int i = 0; i < 300; i++) begin
                    bit acc;
                    do begin
                        @(negedge wr_clk);
                        wr_en   = ($urandom % 4) != 0;
                        wr_data = pattern(seq);
                        acc     = wr_en && !wr_full;
                        if (acc) exp_q.push_back(wr_data);
                    end while (!acc);
                    seq++;
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin
                while (rx_cnt < 300) begin
                    @(negedge rd_clk);
                    rd_en     = ($urandom % 3) != 0;
                    rd_acc_nx = rd_en && !rd_empty;
                end
                @(negedge rd_clk);
                rd_en     = 1'b0;
                rd_acc_nx = 1'b0;
            end
        join
        settle();
        chk(exp_q.size() == 0 && rd_empty, "R1 stream fully delivered", 36'(exp_q.size()), 36'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule